// File: doc/BRIEF.md
# Serial Byte Transmitter with Completion Flag

This block sends one byte at a time as an asynchronous serial frame. It is the transmit side of a combined LIN/UART controller working in plain UART mode. A host on a simple register bus writes a byte to the data register. If the transmitter is enabled and idle, that write starts a frame at once and clears the completion flag. The flag sets again when the stop bit has fully left the line. Software can also clear the flag on its own by writing a one to it. An interrupt level follows the flag while its enable bit is set.

The block holds no queue. Only the byte currently on the line is kept, and the block detects no errors. The bus has no back-pressure: every write completes in its cycle. A data write that arrives while a frame is running, or while the transmitter is disabled, is dropped without notice. Software is expected to poll the busy or done bit, or wait for the interrupt, before writing the next byte. Writing the self-clearing reset bit in the control register puts the block back into a partial reset. This aborts any frame and clears control, status and data, but leaves the bit-rate divisor as it was.

The register map uses an 8-bit bus:
- 0 is the control register: bit 0 enables transmission, bit 1 enables the interrupt, and bit 2 is the soft reset, which always reads 0.
- 1 is the status register: bit 0 is the done flag, bit 1 is busy.
- 2 is the low byte of the divisor and 3 is its high byte.
- 4 is the data register.

Top module: `uatx_core`

## Requirements
- R1: After hardware reset the line is high, irq is low, and control, status and data all read 0x00. The divisor reads back RESET_DIV (low byte at address 2, high byte at address 3).
- R2: A frame has one low start bit, then eight data bits with the LSB first, then one high stop bit. The line is high whenever no frame is running.
- R3: Every bit lasts D+1 clock cycles, where D is the 16-bit divisor. D is captured at the start of a frame, so a divisor write during a frame takes effect only from the next frame.
- R4: A write to address 4 while control bit 0 is 1 and the block is idle starts a frame. The line is low in the cycle after the write edge, and status bit 1 (busy) reads 1 during the frame.
- R5: An accepted data write clears status bit 0 (done). Done sets, and busy clears, at the clock edge 10*(D+1) cycles after the write edge.
- R6: A data write during a frame is ignored. The running frame's bits and timing are unchanged, and address 4 keeps reading the first byte.
- R7: A data write while control bit 0 is 0 is ignored. The line stays high and the status stays 0x00.
- R8: Writing status with bit 0 = 1 clears done, and writing it with bit 0 = 0 leaves done unchanged. If done sets in the same cycle, the set wins.
- R9: irq is high exactly while done and control bit 1 are both 1.
- R10: Writing control with bit 2 = 1 aborts any frame. The line goes high, and busy, done, the control bits and the data register go to 0. The divisor is unchanged, and bit 2 reads back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for the bus and the serial logic |
| rst_n | input | 1 | Active-low hardware reset, asynchronous assert |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data, combinational from rd_addr |
| tx_line | output | 1 | Serial output, idles high |
| irq | output | 1 | Interrupt level: done flag and enable both set |

## Verification
The bench builds the block with DIV_W = 16 and RESET_DIV = 3. The short reset divisor lets the first frames run after only a few dozen cycles. The bench then reprograms the divisor between 0 and 7, which brings the single-cycle bit case (D = 0) within reach. It also writes one value above 255 to exercise the high divisor byte. The short frames let every cycle of each frame be compared against the expected bit, and leave room for many random bytes. They also allow ignored writes and divisor writes to be placed at chosen cycles inside a frame.

// File: rtl/uatx_pkg.sv
package uatx_pkg;
  localparam int BUS_W = 8;
  localparam int CHAR_W = 8;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_STAT = 3'd1;
  localparam logic [2:0] A_DIVL = 3'd2;
  localparam logic [2:0] A_DIVH = 3'd3;
  localparam logic [2:0] A_DATA = 3'd4;

  localparam int CTRL_EN   = 0;
  localparam int CTRL_IE   = 1;
  localparam int CTRL_SRST = 2;
  localparam int STAT_DONE = 0;
  localparam int STAT_BUSY = 1;

  typedef enum logic {TX_IDLE, TX_SEND} tx_state_e;
endpackage

// File: rtl/uatx_baud.sv
module uatx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             start,
  input  logic             run,
  input  logic [DIV_W-1:0] div_in,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      div_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= '0;
      div_q <= div_in;
    end else if (run) begin
      if (cnt_q == div_q) cnt_q <= '0;
      else                cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = run && !start && (cnt_q == div_q);

  // R3: the bit counter never passes the captured divisor
  a_r3_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= div_q);

  // R3: the captured divisor holds while a frame runs
  a_r3_div_held: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start && !clr) |=> $stable(div_q));
endmodule

// File: rtl/uatx_shift.sv
module uatx_shift
  import uatx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [CHAR_W-1:0] char_in,
  input  logic              tick,
  output logic              tx_line,
  output logic              busy,
  output logic              done
);
  localparam int FRAME_W = CHAR_W + 2;
  localparam int IDX_W   = $clog2(FRAME_W);

  tx_state_e          state_q;
  logic [FRAME_W-1:0] frame_q;
  logic [IDX_W-1:0]   idx_q;
  logic               tx_q;
  logic               last_bit;

  assign last_bit = (idx_q == IDX_W'(FRAME_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      frame_q <= '1;
      idx_q   <= '0;
      tx_q    <= 1'b1;
    end else if (clr) begin
      state_q <= TX_IDLE;
      frame_q <= '1;
      idx_q   <= '0;
      tx_q    <= 1'b1;
    end else if (state_q == TX_IDLE) begin
      if (load) begin
        frame_q <= {1'b1, char_in, 1'b0};
        idx_q   <= '0;
        tx_q    <= 1'b0;
        state_q <= TX_SEND;
      end
    end else if (tick) begin
      if (last_bit) begin
        state_q <= TX_IDLE;
        tx_q    <= 1'b1;
      end else begin
        frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
        tx_q    <= frame_q[1];
        idx_q   <= idx_q + 1'b1;
      end
    end
  end

  assign tx_line = tx_q;
  assign busy    = (state_q == TX_SEND);
  assign done    = (state_q == TX_SEND) && tick && last_bit && !clr;

  // R2: line is high whenever no frame runs
  a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx_line);

  // R4: a frame opens with a low start bit
  a_r4_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !tx_line);

  // R2: the stop bit is high when the frame ends
  a_r2_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> tx_line);
endmodule

// File: rtl/uatx_regs.sv
module uatx_regs
  import uatx_pkg::*;
#(
  parameter int DIV_W     = 16,
  parameter int RESET_DIV = 103
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic [2:0]        rd_addr,
  output logic [BUS_W-1:0]  rd_data,
  input  logic              busy,
  input  logic              done,
  output logic              soft_rst,
  output logic              load,
  output logic [CHAR_W-1:0] load_char,
  output logic [DIV_W-1:0]  div,
  output logic              irq
);
  localparam int HI_W = DIV_W - 8;

  logic              en_q, ie_q, flag_q;
  logic [CHAR_W-1:0] data_q;
  logic [DIV_W-1:0]  div_q;
  logic              wr_ctrl, wr_stat, wr_divl, wr_divh, wr_char, w1c;

  assign wr_ctrl  = wr_en && (wr_addr == A_CTRL);
  assign wr_stat  = wr_en && (wr_addr == A_STAT);
  assign wr_divl  = wr_en && (wr_addr == A_DIVL);
  assign wr_divh  = wr_en && (wr_addr == A_DIVH);
  assign wr_char  = wr_en && (wr_addr == A_DATA);
  assign soft_rst = wr_ctrl && wr_data[CTRL_SRST];
  assign load     = wr_char && en_q && !busy;
  assign w1c      = wr_stat && wr_data[STAT_DONE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
      data_q <= '0;
      div_q  <= DIV_W'(RESET_DIV);
    end else begin
      if (soft_rst) begin
        en_q   <= 1'b0;
        ie_q   <= 1'b0;
        data_q <= '0;
      end else if (wr_ctrl) begin
        en_q <= wr_data[CTRL_EN];
        ie_q <= wr_data[CTRL_IE];
      end
      if (load) data_q <= wr_data;

      if (soft_rst)  flag_q <= 1'b0;
      else if (done) flag_q <= 1'b1;
      else if (load) flag_q <= 1'b0;
      else if (w1c)  flag_q <= 1'b0;

      if (wr_divl) div_q[7:0]       <= wr_data;
      if (wr_divh) div_q[DIV_W-1:8] <= wr_data[HI_W-1:0];
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL: begin
        rd_data[CTRL_EN] = en_q;
        rd_data[CTRL_IE] = ie_q;
      end
      A_STAT: begin
        rd_data[STAT_DONE] = flag_q;
        rd_data[STAT_BUSY] = busy;
      end
      A_DIVL:  rd_data = div_q[7:0];
      A_DIVH:  rd_data = BUS_W'(div_q[DIV_W-1:8]);
      A_DATA:  rd_data = data_q;
      default: rd_data = '0;
    endcase
  end

  assign load_char = wr_data;
  assign div       = div_q;
  assign irq       = flag_q && ie_q;

  // R5: done only rises at the end of a frame
  a_r5_flag_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(done));

  // R6: data written during a frame is dropped
  a_r6_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_char && busy && !soft_rst) |=> $stable(data_q));

  // R8: write-one clears done unless a frame ends in the same cycle
  a_r8_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (w1c && !done) |=> !flag_q);

  // R10: soft reset clears flag and enables
  a_r10_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!flag_q && !en_q && !ie_q && !busy));

  // R9: interrupt never stands without the flag
  a_r9_irq_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> rd_data_flag_ok);

  logic rd_data_flag_ok;
  assign rd_data_flag_ok = flag_q;
endmodule

// File: rtl/uatx_core.sv
module uatx_core
  import uatx_pkg::*;
#(
  parameter int DIV_W     = 16,
  parameter int RESET_DIV = 103
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [BUS_W-1:0] wr_data,
  input  logic [2:0]       rd_addr,
  output logic [BUS_W-1:0] rd_data,
  output logic             tx_line,
  output logic             irq
);
  logic              soft_rst, load, busy, done, tick;
  logic [CHAR_W-1:0] load_char;
  logic [DIV_W-1:0]  div;

  uatx_regs #(.DIV_W(DIV_W), .RESET_DIV(RESET_DIV)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .done(done),
    .soft_rst(soft_rst), .load(load), .load_char(load_char),
    .div(div), .irq(irq)
  );

  uatx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .start(load),
    .run(busy), .div_in(div), .tick(tick)
  );

  uatx_shift u_shift (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .load(load),
    .char_in(load_char), .tick(tick),
    .tx_line(tx_line), .busy(busy), .done(done)
  );

  // R5: busy and the line settle together at frame end
  a_r5_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> tx_line);
endmodule

// File: tb/tb_uatx_core.sv
module tb_uatx_core;
  import uatx_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       tx_line, irq;

  int n_chk = 0;
  int n_bad = 0;
  bit summary_done = 1'b0;

  uatx_core #(.DIV_W(16), .RESET_DIV(3)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .tx_line(tx_line), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finish_run();
    if (!summary_done) begin
      summary_done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    finish_run();
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_bit(input logic [7:0] b, input int k);
    if (k == 0) return 1'b0;
    if (k >= 9) return 1'b1;
    return b[k-1];
  endfunction

  task automatic peek(input logic [2:0] a, output logic [7:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_div(input int d);
    wr(A_DIVL, d[7:0]);
    wr(A_DIVH, d[15:8]);
  endtask

  // Sends one byte with bit period d+1 and checks every cycle of the frame.
  // At frame cycle inj (if >= 0) a write of inj_d to inj_a is issued.
  task automatic send_frame(input logic [7:0] b, input int d,
                            input int inj, input logic [2:0] inj_a,
                            input logic [7:0] inj_d);
    logic [7:0] v;
    int len;
    len = 10 * (d + 1);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = A_DATA; wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
    for (int c = 0; c < len; c++) begin
      if (c == inj) begin
        wr_en = 1'b1; wr_addr = inj_a; wr_data = inj_d;
      end else begin
        wr_en = 1'b0;
      end
      chk($sformatf("R2/R3 bit cycle %0d", c), int'(tx_line), int'(exp_bit(b, c / (d + 1))));
      if (c == 0) begin
        peek(A_STAT, v);
        chk("R4/R5 status at frame start", int'(v), 32'h02);
      end
      if (c == len - 1) begin
        peek(A_STAT, v);
        chk("R5 done still clear before last edge", int'(v), 32'h02);
      end
      @(negedge clk);
    end
    wr_en = 1'b0;
    peek(A_STAT, v);
    chk("R5 done set and busy clear at frame end", int'(v), 32'h01);
    chk("R2 idle high after frame", int'(tx_line), 1);
    peek(A_DATA, v);
    chk("R6 data register keeps frame byte", int'(v), int'(b));
  endtask

  initial begin
    logic [7:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 line high", int'(tx_line), 1);
    chk("R1 irq low", int'(irq), 0);
    peek(A_CTRL, v); chk("R1 control", int'(v), 0);
    peek(A_STAT, v); chk("R1 status", int'(v), 0);
    peek(A_DATA, v); chk("R1 data", int'(v), 0);
    peek(A_DIVL, v); chk("R1 divisor low", int'(v), 3);
    peek(A_DIVH, v); chk("R1 divisor high", int'(v), 0);

    // R7 disabled write ignored
    wr(A_DATA, 8'h3C);
    for (int i = 0; i < 8; i++) begin
      chk("R7 line stays high", int'(tx_line), 1);
      @(negedge clk);
    end
    peek(A_STAT, v); chk("R7 status stays zero", int'(v), 0);

    // directed frames
    wr(A_CTRL, 8'h01);
    send_frame(8'hA5, 3, -1, A_DATA, 8'h00);
    set_div(0);
    send_frame(8'h00, 0, -1, A_DATA, 8'h00);
    send_frame(8'hFF, 0, -1, A_DATA, 8'h00);
    set_div(1);
    send_frame(8'h81, 1, -1, A_DATA, 8'h00);

    // R6 write during a frame ignored
    set_div(3);
    send_frame(8'hC3, 3, 5, A_DATA, 8'h5A);
    send_frame(8'h0F, 3, 39, A_DATA, 8'h77);

    // R3 divisor captured at start: change mid frame
    set_div(2);
    send_frame(8'h96, 2, 7, A_DIVL, 8'h07);
    peek(A_DIVL, v); chk("R3 new divisor stored", int'(v), 7);
    send_frame(8'h69, 7, -1, A_DATA, 8'h00);

    // high divisor byte
    set_div(260);
    send_frame(8'h4B, 260, -1, A_DATA, 8'h00);
    set_div(2);

    // R8 write-one-to-clear
    peek(A_STAT, v); chk("R8 flag set before clear", int'(v), 1);
    wr(A_STAT, 8'h00);
    peek(A_STAT, v); chk("R8 zero write keeps flag", int'(v), 1);
    wr(A_STAT, 8'h01);
    peek(A_STAT, v); chk("R8 one write clears flag", int'(v), 0);

    // R9 interrupt level
    wr(A_CTRL, 8'h03);
    chk("R9 irq low with flag clear", int'(irq), 0);
    send_frame(8'h12, 2, -1, A_DATA, 8'h00);
    chk("R9 irq high with flag and enable", int'(irq), 1);
    wr(A_CTRL, 8'h01);
    chk("R9 irq low with enable clear", int'(irq), 0);
    wr(A_CTRL, 8'h03);
    chk("R9 irq back with enable set", int'(irq), 1);
    wr(A_STAT, 8'h01);
    chk("R9 irq low after flag clear", int'(irq), 0);

    // random frames
    for (int i = 0; i < 24; i++) begin
      int d;
      logic [7:0] b;
      int inj;
      d = int'($urandom % 8);
      b = 8'($urandom);
      inj = ($urandom % 2 == 0) ? int'($urandom % (10 * (d + 1))) : -1;
      set_div(d);
      send_frame(b, d, inj, A_DATA, 8'($urandom));
    end

    // R10 soft reset mid frame
    set_div(4);
    wr(A_DATA, 8'hE7);
    repeat (12) @(negedge clk);
    chk("R10 frame running before reset", int'(tx_line), int'(exp_bit(8'hE7, 13 / 5)));
    wr(A_CTRL, 8'h07);
    chk("R10 line high", int'(tx_line), 1);
    peek(A_STAT, v); chk("R10 status cleared", int'(v), 0);
    peek(A_CTRL, v); chk("R10 control cleared, reset bit reads 0", int'(v), 0);
    peek(A_DATA, v); chk("R10 data cleared", int'(v), 0);
    peek(A_DIVL, v); chk("R10 divisor kept", int'(v), 4);
    chk("R10 irq low", int'(irq), 0);
    for (int i = 0; i < 30; i++) begin
      chk("R10 line stays high", int'(tx_line), 1);
      @(negedge clk);
    end
    wr(A_DATA, 8'h11);
    chk("R10 disabled after reset", int'(tx_line), 1);
    wr(A_CTRL, 8'h01);
    send_frame(8'h3D, 4, -1, A_DATA, 8'h00);

    // R10 soft reset clears a set flag
    wr(A_CTRL, 8'h04);
    peek(A_STAT, v); chk("R10 flag cleared by reset", int'(v), 0);

    finish_run();
  end
endmodule